// File: doc/BRIEF.md
# Single-Shot Match Status Bank

This block holds a bank of one-shot match controls for a trace unit. Every control watches a shared vector of comparator match pulses through its own selection mask. When a selected comparator reports a match, the control sets a sticky status flag and emits a one-cycle pulse toward the resource selector. If the resources are paused at that moment, the control also sets a pending flag.

Without re-arm, a control fires once and then stays silent until software writes its status flag back to zero. With re-arm, every selected match fires it again. A 32-bit register port gives software one status word per control. The word carries the status and pending flags, zero reserved bits and read-only capability bits. The port answers one cycle after each request.

Access is gated. An error response is returned whenever external access is not allowed, the software lock is set, or the core has no power. Writes take effect only while the trace unit reports idle.

Top module: `ssc_status_bank`

## Requirements
- R1: A control's status flag (word bit 31) becomes 1 and its `fire` bit pulses high for one cycle, at the clock edge that samples a `cmp_match` bit whose `sel_mask` bit for that control is 1. Matches on comparators whose mask bit is 0 have no effect.
- R2: With `rearm` bit 0, a control whose status flag is 1 ignores further selected matches (no `fire` pulse). The flag stays 1 until a write puts bit 31 to 0, after which the next selected match fires it again.
- R3: With `rearm` bit 1, every selected match produces a `fire` pulse, whatever the status flag holds.
- R4: An accepted match sampled while `res_paused` is 1 sets the pending flag (word bit 30). An accepted match while `res_paused` is 0 leaves the pending flag unchanged.
- R5: In every status word, bits 29..4 and bits 2..1 read 0 and bit 0 reads 1. Bit 3 reads `PE_CAP[n]` for control n.
- R6: Control n answers at byte address 0x2A0 + 4*n, with n from 0 to 7. A write loads the status flag from bit 31 and the pending flag from bit 30. `rsp_valid` is high in the cycle after each `bus_req` cycle, with the read data of that request.
- R7: An address of a control with index at or above `NUM_CTRL` reads 0 without error, and a write to it changes no control.
- R8: While `acc_allowed` is 0, `sw_lock` is 1 or `core_powered` is 0, every request returns `rsp_err` 1 with data 0, and writes have no effect.
- R9: A write that arrives while `unit_idle` is 0 is dropped without error, while reads are still served.
- R10: After reset, all status and pending flags are 0 and `fire` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_match | input | NUM_CMP | Comparator match pulses |
| sel_mask | input | NUM_CTRL*NUM_CMP | Per-control comparator selection, control n in bits [n*NUM_CMP +: NUM_CMP] |
| rearm | input | NUM_CTRL | Per-control re-arm enable |
| res_paused | input | 1 | Resources are in the paused state |
| unit_idle | input | 1 | Trace unit reports idle |
| acc_allowed | input | 1 | External trace access permitted |
| sw_lock | input | 1 | Software lock set |
| core_powered | input | 1 | Core power is on |
| bus_req | input | 1 | Register request valid |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address within the component |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data |
| fire | output | NUM_CTRL | One-cycle pulse per accepted match |

## Verification
The match path is driven with single comparator bits and with bits shared by two controls. This separates mask filtering from cross-talk between controls. Repeated matches on the same comparator tell one-shot blocking (no pulse, flag held) from re-arm (a pulse every time). A paused and an unpaused match show that pending follows only the paused case. Register traffic covers each gating input on its own, a non-idle write, a software write of ones, and writes and reads to unbuilt slots, so that dropped writes can be told from error responses.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int OFF_W    = 12;
  localparam int MAX_CTRL = 8;
  localparam logic [OFF_W-1:0] BANK_BASE = 12'h2A0;

  // Address lies in the 8-word window and is word aligned.
  function automatic logic in_window(input logic [OFF_W-1:0] a);
    return (a[OFF_W-1:5] == BANK_BASE[OFF_W-1:5]) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [2:0] slot_of(input logic [OFF_W-1:0] a);
    return a[4:2];
  endfunction

  // Status word: flags on top, capability bits at the bottom.
  function automatic logic [31:0] pack_word(input logic st, input logic pd, input logic pe);
    return {st, pd, 26'd0, pe, 2'b00, 1'b1};
  endfunction
endpackage

// File: rtl/ssc_slot.sv
module ssc_slot #(
  parameter int NUM_CMP = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CMP-1:0] cmp_match,
  input  logic [NUM_CMP-1:0] sel_mask,
  input  logic               rearm,
  input  logic               paused,
  input  logic               wr_en,
  input  logic               wr_status,
  input  logic               wr_pending,
  output logic               status,
  output logic               pending,
  output logic               fire
);
  logic sel_hit, accept, blocked;
  logic status_nx, pending_nx;

  assign sel_hit = |(cmp_match & sel_mask);
  assign accept  = sel_hit & (rearm | ~status);
  assign blocked = sel_hit & ~accept;

  always_comb begin
    status_nx  = (wr_en ? wr_status  : status)  | accept;
    pending_nx = (wr_en ? wr_pending : pending) | (accept & paused);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= 1'b0;
      pending <= 1'b0;
      fire    <= 1'b0;
    end else begin
      status  <= status_nx;
      pending <= pending_nx;
      fire    <= accept;
    end
  end

  p_fire_status_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> status);
  p_status_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status && !wr_en |=> status);
  p_blocked_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> !fire);
  p_rearm_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit && rearm |=> fire);
  p_pending_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && paused |=> pending);
endmodule

// File: rtl/ssc_regif.sv
module ssc_regif
  import ssc_pkg::*;
#(
  parameter int NUM_CTRL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [OFF_W-1:0] bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             acc_allowed,
  input  logic             sw_lock,
  input  logic             core_powered,
  input  logic             unit_idle,
  input  logic [31:0]      slot_word [NUM_CTRL],
  output logic [NUM_CTRL-1:0] wr_en,
  output logic             wr_status,
  output logic             wr_pending,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [31:0]      rsp_rdata
);
  logic       gate_ok, idx_ok, wr_ok;
  logic [2:0] idx;
  logic [31:0] rd_word;
  logic [29:0] unused_wdata;

  assign unused_wdata = bus_wdata[29:0];
  assign gate_ok  = acc_allowed & ~sw_lock & core_powered;
  assign idx      = slot_of(bus_addr);
  assign idx_ok   = in_window(bus_addr) && (int'(idx) < NUM_CTRL);
  assign wr_ok    = bus_req & bus_we & gate_ok & unit_idle & idx_ok;
  assign wr_status  = bus_wdata[31];
  assign wr_pending = bus_wdata[30];

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CTRL; i++) begin
      wr_en[i] = wr_ok && (int'(idx) == i);
      if (idx_ok && int'(idx) == i) rd_word = slot_word[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_req;
      rsp_err   <= bus_req & ~gate_ok;
      rsp_rdata <= (bus_req && !bus_we && gate_ok) ? rd_word : '0;
    end
  end

  p_layout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[29:4] == 26'd0) && (rsp_rdata[2:1] == 2'b00));
  p_err_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == 32'd0);
  p_rsp_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> rsp_valid);
endmodule

// File: rtl/ssc_status_bank.sv
module ssc_status_bank
  import ssc_pkg::*;
#(
  parameter int NUM_CTRL = 8,
  parameter int NUM_CMP  = 8,
  parameter logic [MAX_CTRL-1:0] PE_CAP = 8'hFF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CMP-1:0]           cmp_match,
  input  logic [NUM_CTRL*NUM_CMP-1:0]  sel_mask,
  input  logic [NUM_CTRL-1:0]          rearm,
  input  logic                         res_paused,
  input  logic                         unit_idle,
  input  logic                         acc_allowed,
  input  logic                         sw_lock,
  input  logic                         core_powered,
  input  logic                         bus_req,
  input  logic                         bus_we,
  input  logic [11:0]                  bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic                         rsp_valid,
  output logic                         rsp_err,
  output logic [31:0]                  rsp_rdata,
  output logic [NUM_CTRL-1:0]          fire
);
  logic [NUM_CTRL-1:0] wr_en, st_q, pd_q;
  logic                wr_status, wr_pending;
  logic [31:0]         slot_word [NUM_CTRL];

  for (genvar n = 0; n < NUM_CTRL; n++) begin : g_slot
    ssc_slot #(.NUM_CMP(NUM_CMP)) i_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmp_match  (cmp_match),
      .sel_mask   (sel_mask[n*NUM_CMP +: NUM_CMP]),
      .rearm      (rearm[n]),
      .paused     (res_paused),
      .wr_en      (wr_en[n]),
      .wr_status  (wr_status),
      .wr_pending (wr_pending),
      .status     (st_q[n]),
      .pending    (pd_q[n]),
      .fire       (fire[n])
    );
    assign slot_word[n] = pack_word(st_q[n], pd_q[n], PE_CAP[n]);
  end

  ssc_regif #(.NUM_CTRL(NUM_CTRL)) i_regif (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .acc_allowed  (acc_allowed),
    .sw_lock      (sw_lock),
    .core_powered (core_powered),
    .unit_idle    (unit_idle),
    .slot_word    (slot_word),
    .wr_en        (wr_en),
    .wr_status    (wr_status),
    .wr_pending   (wr_pending),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata)
  );

  p_write_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en != '0) |-> unit_idle && acc_allowed && !sw_lock && core_powered);
endmodule

// File: tb/test_ssc_status_bank.sv
`timescale 1ns/1ps
module test_ssc_status_bank;
  localparam int NC = 6;
  localparam int NM = 4;
  localparam logic [7:0] PE = 8'h25;
  localparam logic [NC*NM-1:0] MASKS = {4'b0001, 4'b0000, 4'b1000, 4'b1000, 4'b0110, 4'b0001};
  localparam logic [NC-1:0] REARM = 6'b100010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NM-1:0] cmp_match = '0;
  logic res_paused = 1'b0, unit_idle = 1'b1, acc_allowed = 1'b1, sw_lock = 1'b0, core_powered = 1'b1;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NC-1:0] fire;

  int checks = 0, failures = 0;
  logic st [8];
  logic pd [8];

  always #2 clk = ~clk;

  ssc_status_bank #(.NUM_CTRL(NC), .NUM_CMP(NM), .PE_CAP(PE)) i_ssc_status_bank (
    .clk(clk), .rst_n(rst_n), .cmp_match(cmp_match), .sel_mask(MASKS), .rearm(REARM),
    .res_paused(res_paused), .unit_idle(unit_idle), .acc_allowed(acc_allowed),
    .sw_lock(sw_lock), .core_powered(core_powered), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .fire(fire));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] addr_of(input int n);
    return 12'h2A0 + 12'(4 * n);
  endfunction

  function automatic logic [31:0] exp_word(input int n);
    if (n >= NC) return 32'd0;
    return {st[n], pd[n], 26'd0, PE[n], 3'b001};
  endfunction

  function automatic logic gates_open();
    return acc_allowed && !sw_lock && core_powered;
  endfunction

  task automatic bus_op(input logic we, input logic [11:0] a, input logic [31:0] wd,
                        output logic v, output logic e, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    v = rsp_valid; e = rsp_err; d = rsp_rdata;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic read_chk(input string req, input int n);
    logic v, e; logic [31:0] d;
    bus_op(1'b0, addr_of(n), 32'd0, v, e, d);
    chk(req, $sformatf("read valid ctrl%0d", n), {31'd0, v}, 32'd1);
    chk(req, $sformatf("read err ctrl%0d", n), {31'd0, e}, 32'd0);
    chk(req, $sformatf("read word ctrl%0d", n), d, exp_word(n));
  endtask

  task automatic write_op(input string req, input int n, input logic [31:0] wd);
    logic v, e; logic [31:0] d;
    logic exp_e;
    exp_e = !gates_open();
    if (!exp_e && unit_idle && n < NC) begin
      st[n] = wd[31]; pd[n] = wd[30];
    end
    bus_op(1'b1, addr_of(n), wd, v, e, d);
    chk(req, $sformatf("write err ctrl%0d", n), {31'd0, e}, {31'd0, exp_e});
  endtask

  task automatic do_match(input string req, input logic [NM-1:0] vec, input logic paused);
    logic [NC-1:0] exp_fire;
    @(negedge clk);
    cmp_match = vec; res_paused = paused;
    for (int n = 0; n < NC; n++) begin
      logic hit, acc;
      hit = |(vec & MASKS[n*NM +: NM]);
      acc = hit && (REARM[n] || !st[n]);
      exp_fire[n] = acc;
      if (acc) begin
        st[n] = 1'b1;
        if (paused) pd[n] = 1'b1;
      end
    end
    @(negedge clk);
    chk(req, $sformatf("fire after match %b", vec), 32'(fire), 32'(exp_fire));
    cmp_match = '0; res_paused = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10", "fire after reset", 32'(fire), 32'd0);
    chk("R10", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    for (int n = 0; n < 8; n++) read_chk((n < NC) ? "R10" : "R7", n);
  endtask

  task automatic t_select();
    do_match("R1", 4'b0010, 1'b0);
    read_chk("R1", 0);
    read_chk("R1", 1);
    do_match("R1", 4'b0001, 1'b0);
    read_chk("R1", 0);
  endtask

  task automatic t_single_shot();
    do_match("R2", 4'b0001, 1'b0);
    read_chk("R2", 0);
    write_op("R2", 0, 32'h0000_0000);
    read_chk("R6", 0);
    do_match("R2", 4'b0001, 1'b0);
  endtask

  task automatic t_rearm();
    do_match("R3", 4'b0100, 1'b0);
    do_match("R3", 4'b0100, 1'b0);
    do_match("R3", 4'b0001, 1'b0);
    read_chk("R3", 5);
  endtask

  task automatic t_pending();
    do_match("R4", 4'b1000, 1'b1);
    read_chk("R4", 2);
    read_chk("R4", 3);
    do_match("R4", 4'b0110, 1'b0);
    read_chk("R4", 1);
  endtask

  task automatic t_idle_rule();
    unit_idle = 1'b0;
    write_op("R9", 2, 32'h0000_0000);
    read_chk("R9", 2);
    unit_idle = 1'b1;
    write_op("R9", 2, 32'h0000_0000);
    read_chk("R9", 2);
  endtask

  task automatic t_sw_write();
    write_op("R6", 4, 32'hFFFF_FFFF);
    read_chk("R5", 4);
    write_op("R6", 3, 32'h4000_0000);
    read_chk("R6", 3);
  endtask

  task automatic t_gating();
    logic v, e; logic [31:0] d;
    sw_lock = 1'b1;
    bus_op(1'b0, addr_of(4), 32'd0, v, e, d);
    chk("R8", "lock read err", {31'd0, e}, 32'd1);
    chk("R8", "lock read data", d, 32'd0);
    write_op("R8", 4, 32'h0000_0000);
    sw_lock = 1'b0;
    read_chk("R8", 4);
    acc_allowed = 1'b0;
    bus_op(1'b0, addr_of(0), 32'd0, v, e, d);
    chk("R8", "denied read err", {31'd0, e}, 32'd1);
    write_op("R8", 4, 32'h0000_0000);
    acc_allowed = 1'b1;
    core_powered = 1'b0;
    bus_op(1'b0, addr_of(5), 32'd0, v, e, d);
    chk("R8", "unpowered read err", {31'd0, e}, 32'd1);
    chk("R8", "unpowered read data", d, 32'd0);
    write_op("R8", 4, 32'h0000_0000);
    core_powered = 1'b1;
    read_chk("R8", 4);
  endtask

  task automatic t_range();
    write_op("R7", 6, 32'hFFFF_FFFF);
    write_op("R7", 7, 32'h0000_0000);
    read_chk("R7", 6);
    read_chk("R7", 7);
    for (int n = 0; n < NC; n++) read_chk("R7", n);
  endtask

  initial begin
    for (int n = 0; n < 8; n++) begin st[n] = 1'b0; pd[n] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_single_shot();
    t_rearm();
    t_pending();
    t_idle_rule();
    t_sw_write();
    t_gating();
    t_range();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule